// File: doc/BRIEF.md
# Triplicated Serial Shift Register with Live Disagreement Flag

This block is a long serial delay line built for upset-tolerant logic. Every stage keeps three copies of its bit. A 2-of-3 majority voter produces the stage's value, and that voted value feeds all three copies of the following stage. Because each stage votes, an upset in one copy never moves down the chain. The next shift overwrites the damaged copy with clean data.

Each stage also compares its three copies. The mismatch signals of all stages are ORed into one combinational error output, which sits beside the voted serial output. The error output is high in any cycle where at least one stage holds copies that disagree. It drops as soon as a shift rewrites that stage.

Every copy has its own active-low asynchronous clear and preset. These are fed by local tie-off nets: the clear comes from an inverter of constant 0 and the preset from a buffer of constant 1. A glitch on either net shows up as a flipped copy. The board-level reset is asynchronous and active-low, and its release is synchronised to the clock.

Top module: `tmr_shift_reg`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after the synchronised reset releases, `dout` is 0, `err` is 0 and every copy of every stage holds 0. Lowering `rst_n` clears the register at once, without waiting for a clock edge.
- R2: After reset, `dout` following a rising edge equals the `din` value sampled `STAGES` capturing edges earlier. Until `STAGES` capturing edges have occurred, `dout` is 0.
- R3: If a single copy in any stage is flipped, `err` goes to 1 in the same cycle, with no clock edge needed, and `dout` keeps its correct value.
- R4: A flipped single copy is removed by the next rising edge. `err` then returns to 0, and no wrong bit ever reaches `dout` later.
- R5: A low pulse on a copy's preset net sets that copy to 1, and a low pulse on its clear net sets it to 0. When both nets are low together, the clear wins.
- R6: If two copies of the last stage are flipped together, `dout` takes the inverted value and `err` is 1.
- R7: If all three copies of the last stage are flipped together, `dout` takes the inverted value and `err` stays 0, since no disagreement exists.
- R8: `err` is the OR over all stages. Single upsets in two different stages at once raise it, and one rising edge clears both.
- R9: With `din` held at 1 from the moment `rst_n` rises, `dout` first reads 1 after exactly `STAGES`+2 rising edges: two for the reset synchroniser and `STAGES` for the chain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for all stages |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised internally |
| din | input | 1 | Serial data input, captured by stage 0 |
| dout | output | 1 | Majority-voted value of the last stage |
| err | output | 1 | OR of every stage's copy-disagreement signal |

## Verification
The bench streams several bit patterns through the full chain and checks every output bit against the input history. A wrong tap or an off-by-one latency would show up as shifted data. It then pulses preset and clear nets on chosen copies at the first, a middle and the last stage. This catches a voter that forwards a raw copy, which would let the upset propagate. It also catches a flag that misses one stage, or a flag that sticks after the flushing edge. Double and triple upsets in the last stage separate a true majority from a single-copy tap, and separate an equality check from an XOR-style detector. The simultaneous clear-and-preset case catches reversed priority. A cycle count from reset release catches a synchroniser of the wrong depth.

// File: rtl/tmr_sr_pkg.sv
package tmr_sr_pkg;
  localparam int COPIES = 3;
  typedef logic [COPIES-1:0] trio_t;
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_nxt;

  always_comb begin
    sync_nxt = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_nxt;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/tmr_copy_ff.sv
// One copy of a stage bit: async reset, plus a clear net driven by an
// inverter of constant 0 and a preset net driven by a buffer of constant 1.
module tmr_copy_ff (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic gnd_net;
  logic vdd_net;
  logic clr_tie_n;
  logic pre_tie_n;
  logic q_nxt;

  assign gnd_net   = 1'b0;
  assign vdd_net   = 1'b1;
  assign clr_tie_n = ~gnd_net;
  assign pre_tie_n = vdd_net;

  always_comb begin
    q_nxt = d;
  end

  // Clear has priority over preset.
  always_ff @(posedge clk or negedge arst_n or negedge clr_tie_n or negedge pre_tie_n) begin
    if (!arst_n)         q <= 1'b0;
    else if (!clr_tie_n) q <= 1'b0;
    else if (!pre_tie_n) q <= 1'b1;
    else                 q <= q_nxt;
  end
endmodule

// File: rtl/tmr_vote.sv
module tmr_vote
  import tmr_sr_pkg::*;
(
  input  trio_t trio,
  output logic  vote,
  output logic  split
);
  always_comb begin
    vote  = (trio[0] & trio[1]) | (trio[1] & trio[2]) | (trio[0] & trio[2]);
    split = (trio[0] ^ trio[1]) | (trio[1] ^ trio[2]);
  end
endmodule

// File: rtl/tmr_stage.sv
module tmr_stage
  import tmr_sr_pkg::*;
(
  input  logic  clk,
  input  logic  arst_n,
  input  logic  d,
  output trio_t copies,
  output logic  vote,
  output logic  split
);
  for (genvar c = 0; c < COPIES; c++) begin : g_copy
    tmr_copy_ff u_ff (
      .clk    (clk),
      .arst_n (arst_n),
      .d      (d),
      .q      (copies[c])
    );
  end

  tmr_vote u_vote (
    .trio  (copies),
    .vote  (vote),
    .split (split)
  );
endmodule

// File: rtl/tmr_shift_reg.sv
module tmr_shift_reg
  import tmr_sr_pkg::*;
#(
  parameter int STAGES = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout,
  output logic err
);
  localparam int NCOPY = STAGES * COPIES;

  logic              rst_sync_n;
  logic [STAGES-1:0] stage_vote;
  logic [STAGES-1:0] stage_split;
  logic [STAGES-1:0] stage_d;
  logic [NCOPY-1:0]  copies;

  tmr_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_head
      assign stage_d[s] = din;
    end else begin : g_body
      assign stage_d[s] = stage_vote[s-1];
    end

    tmr_stage u_stage (
      .clk    (clk),
      .arst_n (rst_sync_n),
      .d      (stage_d[s]),
      .copies (copies[s*COPIES +: COPIES]),
      .vote   (stage_vote[s]),
      .split  (stage_split[s])
    );
  end

  assign dout = stage_vote[STAGES-1];
  assign err  = |stage_split;
endmodule

// File: rtl/tmr_shift_reg_chk.sv
module tmr_shift_reg_chk #(
  parameter int STAGES = 100
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  sync_n,
  input logic                  din,
  input logic                  dout,
  input logic                  err,
  input logic [3*STAGES-1:0]   copies
);
  logic [STAGES-1:0] split_chk;
  logic [STAGES-1:0] maj_chk;

  always_comb begin
    for (int k = 0; k < STAGES; k++) begin
      split_chk[k] = (copies[3*k +: 3] != 3'b000) && (copies[3*k +: 3] != 3'b111);
      maj_chk[k]   = ($countones(copies[3*k +: 3]) >= 2);
    end
  end

  // R1: fresh after synchronised release
  a_r1_clean_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_n) |-> (copies == '0 && !err && !dout));

  // R3 / R8: flag tracks any stage disagreement
  a_r3_flag_any_split: assert property (@(posedge clk) disable iff (!rst_n)
    err == (|split_chk));

  // R6 / R7: output is the majority of the last stage copies
  a_r6_tail_majority: assert property (@(posedge clk) disable iff (!rst_n)
    dout == maj_chk[STAGES-1]);

  // R2 / R4: an undisturbed stage holds the vote of its predecessor from one edge back
  for (genvar k = 0; k < STAGES-1; k++) begin : g_cap
    if (k == 0) begin : g_first
      a_r2_capture_head: assert property (@(posedge clk) disable iff (!rst_n || !sync_n)
        (!split_chk[0] && $past(sync_n)) |-> (copies[2:0] == {3{$past(din)}}));
    end else begin : g_next
      a_r4_capture_vote: assert property (@(posedge clk) disable iff (!rst_n || !sync_n)
        (!split_chk[k] && $past(sync_n)) |-> (copies[3*k +: 3] == {3{$past(maj_chk[k-1])}}));
    end
  end
endmodule

bind tmr_shift_reg tmr_shift_reg_chk #(.STAGES(STAGES)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .sync_n (rst_sync_n),
  .din    (din),
  .dout   (dout),
  .err    (err),
  .copies (copies)
);

// File: tb/tmr_shift_reg_bench.sv
`timescale 1ns/1ps
module tmr_shift_reg_bench;
  localparam int N = 100;

  logic clk = 1'b0;
  logic rst_n;
  logic din;
  logic dout;
  logic err;

  int total = 0;
  int fails = 0;
  int ne = 0;
  bit hist [0:4095];

  always #2.5 clk = ~clk;

  tmr_shift_reg #(.STAGES(N)) u_tmr_shift_reg (
    .clk (clk), .rst_n (rst_n), .din (din), .dout (dout), .err (err)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit stage_val(input int s);
    return (ne - s >= 1) ? hist[ne - s] : 1'b0;
  endfunction

  function automatic bit exp_dout();
    return stage_val(N - 1);
  endfunction

  // one capturing edge; ends at the following falling edge
  task automatic step(input bit b);
    din = b;
    hist[ne + 1] = b;
    @(posedge clk);
    ne++;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async dout", dout, 1'b0);
    chk("R1 async err", err, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    din = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    ne = 0;
    chk("R1 released dout", dout, 1'b0);
    chk("R1 released err", err, 1'b0);
  endtask

  // sites: 0..2 = last stage copies 0..2, 3 = stage 0 copy 1, 4 = stage 57 copy 2
  // mode: 0 preset only, 1 clear only, 2 both
  task automatic apply(input int site, input int mode, input bit on);
    case (site)
      0: if (on) begin
           if (mode != 1) force u_tmr_shift_reg.g_stage[99].u_stage.g_copy[0].u_ff.pre_tie_n = 1'b0;
           if (mode != 0) force u_tmr_shift_reg.g_stage[99].u_stage.g_copy[0].u_ff.clr_tie_n = 1'b0;
         end else begin
           release u_tmr_shift_reg.g_stage[99].u_stage.g_copy[0].u_ff.pre_tie_n;
           release u_tmr_shift_reg.g_stage[99].u_stage.g_copy[0].u_ff.clr_tie_n;
         end
      1: if (on) begin
           if (mode != 1) force u_tmr_shift_reg.g_stage[99].u_stage.g_copy[1].u_ff.pre_tie_n = 1'b0;
           if (mode != 0) force u_tmr_shift_reg.g_stage[99].u_stage.g_copy[1].u_ff.clr_tie_n = 1'b0;
         end else begin
           release u_tmr_shift_reg.g_stage[99].u_stage.g_copy[1].u_ff.pre_tie_n;
           release u_tmr_shift_reg.g_stage[99].u_stage.g_copy[1].u_ff.clr_tie_n;
         end
      2: if (on) begin
           if (mode != 1) force u_tmr_shift_reg.g_stage[99].u_stage.g_copy[2].u_ff.pre_tie_n = 1'b0;
           if (mode != 0) force u_tmr_shift_reg.g_stage[99].u_stage.g_copy[2].u_ff.clr_tie_n = 1'b0;
         end else begin
           release u_tmr_shift_reg.g_stage[99].u_stage.g_copy[2].u_ff.pre_tie_n;
           release u_tmr_shift_reg.g_stage[99].u_stage.g_copy[2].u_ff.clr_tie_n;
         end
      3: if (on) begin
           if (mode != 1) force u_tmr_shift_reg.g_stage[0].u_stage.g_copy[1].u_ff.pre_tie_n = 1'b0;
           if (mode != 0) force u_tmr_shift_reg.g_stage[0].u_stage.g_copy[1].u_ff.clr_tie_n = 1'b0;
         end else begin
           release u_tmr_shift_reg.g_stage[0].u_stage.g_copy[1].u_ff.pre_tie_n;
           release u_tmr_shift_reg.g_stage[0].u_stage.g_copy[1].u_ff.clr_tie_n;
         end
      default: if (on) begin
           if (mode != 1) force u_tmr_shift_reg.g_stage[57].u_stage.g_copy[2].u_ff.pre_tie_n = 1'b0;
           if (mode != 0) force u_tmr_shift_reg.g_stage[57].u_stage.g_copy[2].u_ff.clr_tie_n = 1'b0;
         end else begin
           release u_tmr_shift_reg.g_stage[57].u_stage.g_copy[2].u_ff.pre_tie_n;
           release u_tmr_shift_reg.g_stage[57].u_stage.g_copy[2].u_ff.clr_tie_n;
         end
    endcase
  endtask

  function automatic int site_stage(input int site);
    return (site <= 2) ? 99 : (site == 3) ? 0 : 57;
  endfunction

  // flip a copy against its current value: preset if it holds 0, clear if 1
  task automatic flip_on(input int site);
    apply(site, stage_val(site_stage(site)) ? 1 : 0, 1'b1);
  endtask

  task automatic pulse_off(input int a, input int b, input int c);
    #0.5;
    apply(a, 0, 1'b0);
    if (b >= 0) apply(b, 0, 1'b0);
    if (c >= 0) apply(c, 0, 1'b0);
    #0.5;
  endtask

  function automatic bit pat(input int p, input int e);
    case (p)
      0: return e[0];
      1: return 1'b1;
      2: return bit'(((e * 1103515245 + 12345) >>> 11) & 1);
      default: return bit'((e / 7) & 1);
    endcase
  endfunction

  initial begin
    #1000000;
    fails++;
    total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int cnt;
    bit v;
    rst_n = 1'b0;
    din   = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset dout", dout, 1'b0);
    chk("R1 reset err", err, 1'b0);

    // R9: latency from reset release with din held high
    rst_n = 1'b1;
    din   = 1'b1;
    cnt   = 0;
    while (dout !== 1'b1 && cnt < 400) begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
    end
    chk_int("R9 edges to first one", cnt, N + 2);

    do_reset();

    // R2: stream patterns end to end
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 2 * N + 17; i++) begin
        step(pat(p, ne + 1));
        chk($sformatf("R2 pattern %0d edge %0d", p, ne), dout, exp_dout());
        if (err !== 1'b0) chk("R2 err quiet", err, 1'b0);
      end
    end

    // checkerboard fill so the last stage alternates
    for (int i = 0; i < N + 1; i++) step(pat(0, ne + 1));

    // R3/R4: single upset at the last stage
    for (int s = 0; s < 3; s++) begin
      v = exp_dout();
      flip_on(s);
      pulse_off(s, -1, -1);
      chk($sformatf("R3 last copy %0d err", s), err, 1'b1);
      chk($sformatf("R3 last copy %0d dout", s), dout, v);
      step(pat(0, ne + 1));
      chk("R4 flushed err", err, 1'b0);
      chk("R4 flushed dout", dout, exp_dout());
    end

    // R3/R4: head and middle stages, then watch the whole chain drain
    for (int s = 3; s < 5; s++) begin
      v = exp_dout();
      flip_on(s);
      pulse_off(s, -1, -1);
      chk($sformatf("R3 site %0d err", s), err, 1'b1);
      chk($sformatf("R3 site %0d dout", s), dout, v);
      step(pat(2, ne + 1));
      chk("R4 inner flushed err", err, 1'b0);
      for (int i = 0; i < N; i++) begin
        step(pat(2, ne + 1));
        chk("R4 no propagation", dout, exp_dout());
      end
    end

    // R8: two stages at once
    flip_on(3);
    flip_on(4);
    pulse_off(3, 4, -1);
    chk("R8 two stages err", err, 1'b1);
    step(pat(0, ne + 1));
    chk("R8 both flushed", err, 1'b0);
    for (int i = 0; i < N; i++) step(pat(0, ne + 1));

    // R6: double upset in last stage
    v = exp_dout();
    flip_on(0);
    flip_on(1);
    pulse_off(0, 1, -1);
    chk("R6 double dout", dout, ~v);
    chk("R6 double err", err, 1'b1);
    step(pat(0, ne + 1));
    chk("R6 recovered dout", dout, exp_dout());
    chk("R6 recovered err", err, 1'b0);

    // R7: triple upset in last stage
    v = exp_dout();
    flip_on(0);
    flip_on(1);
    flip_on(2);
    pulse_off(0, 1, 2);
    chk("R7 triple dout", dout, ~v);
    chk("R7 triple err", err, 1'b0);
    step(pat(0, ne + 1));
    chk("R7 recovered dout", dout, exp_dout());

    // R5: clear and preset low together, twice (last stage alternates)
    for (int t = 0; t < 2; t++) begin
      v = exp_dout();
      apply(0, 2, 1'b1);
      pulse_off(0, -1, -1);
      chk($sformatf("R5 clear wins err (held %0b)", v), err, v);
      chk("R5 clear wins dout", dout, v);
      step(pat(0, ne + 1));
      chk("R5 recovered err", err, 1'b0);
    end

    // R1: async reset in mid-stream
    do_reset();
    step(1'b1);
    chk("R1 after re-reset dout", dout, 1'b0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule